// File: doc/BRIEF.md
# Chipset Reset Pulse Generator

This block turns single-cycle request strobes into timed reset pulses toward a platform controller. A cold request holds the power-ok line low for a fixed number of microseconds, then lets it return high. A warm request pulls an active-low reset-request line low for a shorter fixed time. The cold pulse forces power to drop on the platform. The warm pulse only reinitialises the processor and leaves power alone.

A shutdown request overrides both pulses. It latches a drive that holds deep-sleep power-ok low and resume reset asserted. The drive stays latched until the power sequencer reports that hard-off has been reached. Pulse widths are given as microsecond parameters and timed by a clock prescaler derived from the clock frequency. Elaboration stops if a width is below the platform minimum: 91 us for the cold pulse and 500 ns for the warm pulse.

Top module: `chipset_rst_pulser`

## Requirements
- R1: After reset, `pwrok_force_low` is 0, `rcin_n` is 1, `shut_drive` is 0 and `busy` is 0.
- R2: A cold request sampled while `pwr_ok` is 0 has no effect: `pwrok_force_low` stays 0 and `busy` stays 0.
- R3: An accepted cold request makes `pwrok_force_low` 1 from the cycle after the request for exactly COLD_US × CLK_HZ / 1,000,000 cycles, then returns it to 0. The default is 5000 cycles.
- R4: An accepted warm request makes `rcin_n` 0 for exactly WARM_US × CLK_HZ / 1,000,000 cycles, with a default of 500 cycles, and then returns it to 1. `pwrok_force_low` stays 0 throughout a warm pulse.
- R5: A shutdown request sets `shut_drive` to 1 on the next cycle. It stays 1 until a cycle in which `hardoff_reached` is 1 and `shut_req` is 0, and clears on the following cycle.
- R6: A shutdown request during a pulse ends the pulse. On the next cycle `pwrok_force_low` is 0 and `rcin_n` is 1.
- R7: `busy` is 1 whenever a pulse is running or `shut_drive` is 1, and 0 otherwise.
- R8: Cold and warm requests that arrive while `busy` is 1 are ignored. The running pulse keeps its length and the other line stays idle. If cold and warm requests are accepted in the same cycle, cold wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cold_req | input | 1 | Cold reset request strobe |
| warm_req | input | 1 | Warm reset request strobe |
| shut_req | input | 1 | Forced shutdown request strobe |
| pwr_ok | input | 1 | Present level of power-ok |
| hardoff_reached | input | 1 | Sequencer release: hard-off reached |
| pwrok_force_low | output | 1 | 1 = drive power-ok low |
| rcin_n | output | 1 | Active-low reset-request line |
| shut_drive | output | 1 | 1 = hold deep-sleep power-ok low and resume reset asserted |
| busy | output | 1 | Pulse running or shutdown held |

## Verification
Some rules can be checked on every cycle, and assertions cover them. These are the cold no-op when power-ok is low, warm pulses never touching power-ok, shutdown taking effect one cycle later and holding until released, and `busy` covering every active line. Other behaviours only show up in the bench's scenarios. These are the exact pulse lengths in cycles, requests ignored in the middle of a pulse with the pulse length unchanged, and the choice between simultaneous requests.

// File: rtl/chipset_rst_pulser.sv
module chipset_rst_pulser #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int COLD_US     = 100,
  parameter int WARM_US     = 10,
  parameter int COLD_MIN_NS = 91_000,
  parameter int WARM_MIN_NS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cold_req,
  input  logic warm_req,
  input  logic shut_req,
  input  logic pwr_ok,
  input  logic hardoff_reached,
  output logic pwrok_force_low,
  output logic rcin_n,
  output logic shut_drive,
  output logic busy
);

  localparam int TPU    = CLK_HZ / 1_000_000;
  localparam int PW     = (TPU > 1) ? $clog2(TPU) : 1;
  localparam int MAX_US = (COLD_US > WARM_US) ? COLD_US : WARM_US;
  localparam int UW     = $clog2(MAX_US + 1);

  if (TPU < 1) begin : g_bad_clk
    $error("clock below 1 MHz cannot time microseconds");
  end
  if (COLD_US * 1000 < COLD_MIN_NS) begin : g_bad_cold
    $error("cold pulse shorter than its minimum");
  end
  if (WARM_US * 1000 < WARM_MIN_NS) begin : g_bad_warm
    $error("warm pulse shorter than its minimum");
  end

  typedef enum logic [1:0] {IDLE, COLD, WARM} mode_t;

  mode_t          mode_q;
  logic [PW-1:0]  pre_q;
  logic [UW-1:0]  us_q;
  logic           shut_q;

  wire            pre_wrap   = (pre_q == PW'(TPU - 1));
  wire [UW-1:0]   last_us    = (mode_q == COLD) ? UW'(COLD_US - 1) : UW'(WARM_US - 1);
  wire            pulse_done = pre_wrap && (us_q == last_us);

  assign busy            = (mode_q != IDLE) || shut_q;
  assign pwrok_force_low = (mode_q == COLD);
  assign rcin_n          = (mode_q != WARM);
  assign shut_drive      = shut_q;

  wire start_cold = cold_req && !busy && !shut_req && pwr_ok;
  wire start_warm = warm_req && !busy && !shut_req && !start_cold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_q <= 1'b0;
    end else if (shut_req) begin
      shut_q <= 1'b1;
    end else if (hardoff_reached) begin
      shut_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= IDLE;
      pre_q  <= '0;
      us_q   <= '0;
    end else if (shut_req || mode_q == IDLE || pulse_done) begin
      pre_q  <= '0;
      us_q   <= '0;
      if (shut_req || mode_q != IDLE) mode_q <= IDLE;
      else if (start_cold)            mode_q <= COLD;
      else if (start_warm)            mode_q <= WARM;
    end else if (pre_wrap) begin
      pre_q <= '0;
      us_q  <= us_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assert_cold_noop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cold_req && !warm_req && !shut_req && !busy && !pwr_ok) |=> (!pwrok_force_low && !busy));

  assert_warm_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rcin_n |-> !pwrok_force_low);

  assert_shut_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shut_req |=> shut_drive);

  assert_shut_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_drive && !hardoff_reached) |=> shut_drive);

  assert_shut_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shut_req |=> (rcin_n && !pwrok_force_low));

  assert_busy_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rcin_n || pwrok_force_low || shut_drive) |-> busy);

  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrok_force_low && !shut_req && !$past(shut_req)) |=> rcin_n);

endmodule

// File: tb/chipset_rst_pulser_tb.sv
module chipset_rst_pulser_tb_top;
  localparam int COLD_CYC = 5000;
  localparam int WARM_CYC = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cold_req = 1'b0, warm_req = 1'b0, shut_req = 1'b0;
  logic pwr_ok = 1'b1, hardoff_reached = 1'b0;
  logic pwrok_force_low, rcin_n, shut_drive, busy;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  chipset_rst_pulser dut_i (
    .clk(clk), .rst_n(rst_n), .cold_req(cold_req), .warm_req(warm_req),
    .shut_req(shut_req), .pwr_ok(pwr_ok), .hardoff_reached(hardoff_reached),
    .pwrok_force_low(pwrok_force_low), .rcin_n(rcin_n),
    .shut_drive(shut_drive), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic t_reset();
    check(pwrok_force_low == 0, "R1 pwrok_force_low", int'(pwrok_force_low), 0);
    check(rcin_n == 1, "R1 rcin_n", int'(rcin_n), 1);
    check(shut_drive == 0, "R1 shut_drive", int'(shut_drive), 0);
    check(busy == 0, "R1 busy", int'(busy), 0);
  endtask

  task automatic t_cold();
    int len = 0;
    bit warm_seen = 0;
    cold_req = 1;
    @(negedge clk);
    cold_req = 0;
    check(busy == 1, "R7 busy at cold start", int'(busy), 1);
    while (pwrok_force_low && len < 20000) begin
      len++;
      if (!rcin_n) warm_seen = 1;
      @(negedge clk);
    end
    check(len == COLD_CYC, "R3 cold pulse length", len, COLD_CYC);
    check(!warm_seen, "R3 rcin_n idle during cold", int'(warm_seen), 0);
    check(busy == 0, "R7 busy after cold", int'(busy), 0);
  endtask

  task automatic t_cold_noop();
    pwr_ok = 0;
    cold_req = 1;
    @(negedge clk);
    cold_req = 0;
    check(pwrok_force_low == 0, "R2 no pulse when power-ok low", int'(pwrok_force_low), 0);
    check(busy == 0, "R2 busy stays low", int'(busy), 0);
    repeat (5) @(negedge clk);
    check(pwrok_force_low == 0, "R2 still no pulse", int'(pwrok_force_low), 0);
    pwr_ok = 1;
  endtask

  task automatic t_warm();
    int len = 0;
    bit cold_seen = 0;
    warm_req = 1;
    @(negedge clk);
    warm_req = 0;
    while (!rcin_n && len < 20000) begin
      len++;
      if (pwrok_force_low) cold_seen = 1;
      @(negedge clk);
    end
    check(len == WARM_CYC, "R4 warm pulse length", len, WARM_CYC);
    check(!cold_seen, "R4 power-ok untouched by warm", int'(cold_seen), 0);
    check(rcin_n == 1, "R4 rcin_n released", int'(rcin_n), 1);
  endtask

  task automatic t_ignore_busy();
    int len = 0;
    bit warm_seen = 0;
    cold_req = 1;
    @(negedge clk);
    cold_req = 0;
    while (pwrok_force_low && len < 20000) begin
      len++;
      warm_req = (len == 100);
      cold_req = (len == 200);
      if (!rcin_n) warm_seen = 1;
      @(negedge clk);
    end
    warm_req = 0;
    cold_req = 0;
    check(len == COLD_CYC, "R8 cold length unchanged by requests", len, COLD_CYC);
    check(!warm_seen, "R8 warm ignored while busy", int'(warm_seen), 0);
    repeat (3) @(negedge clk);
    check(!pwrok_force_low && rcin_n, "R8 no late pulse", int'(pwrok_force_low), 0);
  endtask

  task automatic t_simultaneous();
    cold_req = 1;
    warm_req = 1;
    @(negedge clk);
    cold_req = 0;
    warm_req = 0;
    check(pwrok_force_low == 1, "R8 cold wins tie", int'(pwrok_force_low), 1);
    check(rcin_n == 1, "R8 warm loses tie", int'(rcin_n), 1);
    while (busy) @(negedge clk);
  endtask

  task automatic t_shutdown();
    shut_req = 1;
    @(negedge clk);
    shut_req = 0;
    check(shut_drive == 1, "R5 shutdown set", int'(shut_drive), 1);
    check(busy == 1, "R7 busy during shutdown", int'(busy), 1);
    cold_req = 1;
    @(negedge clk);
    cold_req = 0;
    repeat (40) @(negedge clk);
    check(shut_drive == 1, "R5 shutdown held", int'(shut_drive), 1);
    check(pwrok_force_low == 0, "R8 cold ignored during shutdown", int'(pwrok_force_low), 0);
    shut_req = 1;
    hardoff_reached = 1;
    @(negedge clk);
    shut_req = 0;
    check(shut_drive == 1, "R5 request beats release", int'(shut_drive), 1);
    @(negedge clk);
    hardoff_reached = 0;
    check(shut_drive == 0, "R5 released at hard-off", int'(shut_drive), 0);
    check(busy == 0, "R7 busy clear after release", int'(busy), 0);
  endtask

  task automatic t_abort();
    warm_req = 1;
    @(negedge clk);
    warm_req = 0;
    repeat (20) @(negedge clk);
    shut_req = 1;
    @(negedge clk);
    shut_req = 0;
    check(rcin_n == 1, "R6 warm aborted", int'(rcin_n), 1);
    check(shut_drive == 1, "R6 shutdown active", int'(shut_drive), 1);
    hardoff_reached = 1;
    @(negedge clk);
    hardoff_reached = 0;
    cold_req = 1;
    @(negedge clk);
    cold_req = 0;
    repeat (30) @(negedge clk);
    shut_req = 1;
    @(negedge clk);
    shut_req = 0;
    check(pwrok_force_low == 0, "R6 cold aborted", int'(pwrok_force_low), 0);
    hardoff_reached = 1;
    @(negedge clk);
    hardoff_reached = 0;
    @(negedge clk);
    check(busy == 0, "R7 idle after abort", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cold();
    t_cold_noop();
    t_warm();
    t_ignore_busy();
    t_simultaneous();
    t_shutdown();
    t_abort();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end
endmodule